// File: doc/BRIEF.md
# Interleaved Sixteen-Source Interrupt Controller

This block merges two groups of interrupt requests into one processor interrupt line. One group is a set of external request pins. The other is a set of internal peripheral levels. The two groups share a single priority ladder in which the groups take turns: external pin 0 has the highest priority, internal level 0 comes next, then external pin 1, then internal level 1, and so on down to the last internal level.

Software reaches the controller over a small word-addressed register bus. The bus gives access to three registers. The pending register shows which sources are requesting. The mask register enables each source. The vector register reports the most urgent source that is both pending and enabled, multiplied by four, so that an interrupt handler can add it straight to the base of a jump table. Requests are level-sensitive and are expected to arrive already synchronous to the clock.

Top module: `ilv_intc`

## Requirements
- R1: After a synchronous reset the mask register reads 0, `irq_o` is low, and the vector register reads 64.
- R2: Priority position 2k is external pin k and position 2k+1 is internal level k. Position 0 is the most urgent. Bit i of the pending register (address 0) and of the mask register shows position i.
- R3: A pending bit is level-sensitive. It is registered one clock after its request input changes, so it sets while the input is high and clears once the input drops.
- R4: A write to address 0 is ignored. Both the pending value and the mask register stay unchanged.
- R5: The mask register at address 1 is read/write and holds one bit per position in bits 15:0. Bits above 15 read as 0.
- R6: `irq_o` is a registered output. It is high exactly one clock after a cycle in which some pending bit has its mask bit set, which is two clocks after the request input rises.
- R7: The vector register at address 2 is read-only and reads 4 × c. Here c is the lowest-numbered position that is both pending and enabled.
- R8: When no enabled source is pending, the vector register reads 64 (c = 16).
- R9: A disabled source is left out of the vector even when it has higher priority than an enabled pending source.
- R10: Address 3 reads 0. Writes to address 2 or address 3 change no register.
- R11: Read data is registered. `bus_rdata` shows the register that was selected at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Word address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ext_req | input | 8 | External request pins, index 0 most urgent |
| int_req | input | 8 | Internal peripheral levels, index 0 most urgent |
| irq_o | output | 1 | Processor interrupt line |

## Verification
A pending register that fails to track its inputs shows up in the next pending read. It also appears as `irq_o` rising or falling one cycle late or not at all. A mask bit that flips or gets stuck changes the vector read and the interrupt line on the very next read. A fault in the interleave or the priority encoder only becomes visible when two sources compete. For that reason the vector table pairs neighbouring external and internal sources, covers both ends of the ladder, and includes masked sources that outrank unmasked ones.

// File: rtl/ilv_intc_pkg.sv
package ilv_intc_pkg;

  // Register addresses on the bus
  typedef enum logic [1:0] {
    REG_PEND  = 2'd0,
    REG_MASK  = 2'd1,
    REG_VEC   = 2'd2,
    REG_SPARE = 2'd3
  } reg_sel_e;

  localparam int VEC_SHIFT = 2;  // vector reads code * 4

endpackage

// File: rtl/ilv_intc_merge.sv
module ilv_intc_merge #(
  parameter int NUM_PAIRS = 8,
  localparam int NUM_SRC  = 2 * NUM_PAIRS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PAIRS-1:0] ext_req,
  input  logic [NUM_PAIRS-1:0] int_req,
  output logic [NUM_SRC-1:0]   pend_q
);

  logic [NUM_SRC-1:0] woven;

  // Even positions take the external pins, odd positions the internal levels
  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_weave
    assign woven[2*k]   = ext_req[k];
    assign woven[2*k+1] = int_req[k];
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= woven;
  end

  logic seen_q;
  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= 1'b1;
  end

  AST_PEND_TRACKS: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> ($countones(pend_q) == $past($countones(ext_req) + $countones(int_req)))); // R3

endmodule

// File: rtl/ilv_intc_prio.sv
module ilv_intc_prio #(
  parameter int NUM_SRC = 16,
  localparam int CODE_W = $clog2(NUM_SRC + 1),
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] active,
  output logic [CODE_W-1:0]  code
);

  localparam logic [CODE_W-1:0] NONE = CODE_W'(NUM_SRC);

  // Lowest set bit wins; scanning downward leaves the lowest one last
  always_comb begin
    code = NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (active[i]) code = CODE_W'(i);
    end
  end

  logic [NUM_SRC-1:0] below;
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) below[i] = (CODE_W'(i) < code);
  end

  AST_CODE_HIT:   assert property (@(posedge clk) disable iff (rst)
    (code != NONE) |-> active[code[IDX_W-1:0]]); // R7
  AST_CODE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (active & below) == '0); // R9
  AST_CODE_NONE:  assert property (@(posedge clk) disable iff (rst)
    (code == NONE) |-> (active == '0)); // R8

endmodule

// File: rtl/ilv_intc_regs.sv
module ilv_intc_regs
  import ilv_intc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 16,
  localparam int CODE_W = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         addr,
  input  logic               wr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [CODE_W-1:0]  code,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [DATA_W-1:0]  rdata_q
);

  reg_sel_e sel;
  assign sel = reg_sel_e'(addr);

  always_ff @(posedge clk) begin
    if (rst)                          mask_q <= '0;
    else if (wr && sel == REG_MASK)   mask_q <= wdata[NUM_SRC-1:0];
  end

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    unique case (sel)
      REG_PEND: rd_next = DATA_W'(pend);
      REG_MASK: rd_next = DATA_W'(mask_q);
      REG_VEC:  rd_next = DATA_W'(code) << VEC_SHIFT;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr && sel != REG_MASK) |=> $stable(mask_q)); // R4
  AST_RD_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sel == REG_SPARE) |=> (rdata_q == '0)); // R10

endmodule

// File: rtl/ilv_intc.sv
module ilv_intc #(
  parameter int NUM_PAIRS = 8,
  parameter int DATA_W    = 32,
  localparam int NUM_SRC  = 2 * NUM_PAIRS,
  localparam int CODE_W   = $clog2(NUM_SRC + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           bus_addr,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_PAIRS-1:0] ext_req,
  input  logic [NUM_PAIRS-1:0] int_req,
  output logic                 irq_o
);

  localparam logic [CODE_W-1:0] NONE = CODE_W'(NUM_SRC);

  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] live;
  logic [CODE_W-1:0]  code;

  ilv_intc_merge #(.NUM_PAIRS(NUM_PAIRS)) u_merge (
    .clk     (clk),
    .rst     (rst),
    .ext_req (ext_req),
    .int_req (int_req),
    .pend_q  (pend_q)
  );

  assign live = pend_q & mask_q;

  ilv_intc_prio #(.NUM_SRC(NUM_SRC)) u_prio (
    .clk    (clk),
    .rst    (rst),
    .active (live),
    .code   (code)
  );

  ilv_intc_regs #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .wr      (bus_wr),
    .wdata   (bus_wdata),
    .pend    (pend_q),
    .code    (code),
    .mask_q  (mask_q),
    .rdata_q (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |live;
  end

  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    (code == NONE) |=> !irq_o); // R6
  AST_IRQ_FIRE: assert property (@(posedge clk) disable iff (rst)
    (code != NONE) |=> irq_o); // R6

endmodule

// File: tb/sim_ilv_intc.sv
module sim_ilv_intc;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  ext_req = '0;
  logic [7:0]  int_req = '0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ilv_intc u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_req(ext_req), .int_req(int_req), .irq_o(irq_o)
  );

  // {ext, int, mask, expected vector read}
  localparam int NVEC = 10;
  localparam logic [39:0] TBL [NVEC] = '{
    {8'h01, 8'h00, 16'hFFFF, 8'd0},
    {8'h00, 8'h01, 16'hFFFF, 8'd4},
    {8'h02, 8'h01, 16'hFFFF, 8'd4},
    {8'h80, 8'h80, 16'hFFFF, 8'd56},
    {8'h00, 8'h80, 16'hFFFF, 8'd60},
    {8'h01, 8'h01, 16'hFFFE, 8'd4},
    {8'hFF, 8'hFF, 16'h0000, 8'd64},
    {8'h10, 8'h08, 16'hFFFF, 8'd28},
    {8'h10, 8'h08, 16'h0100, 8'd32},
    {8'h00, 8'h00, 16'hFFFF, 8'd64}
  };

  function automatic logic [31:0] weave(input logic [7:0] e, input logic [7:0] n);
    logic [31:0] w = '0;
    for (int k = 0; k < 8; k++) begin
      w[2*k]   = e[k];
      w[2*k+1] = n[k];
    end
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic drive_settle(input logic [7:0] e, input logic [7:0] n);
    @(negedge clk);
    ext_req = e; int_req = n;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq after reset", {31'b0, irq_o}, 32'd0);
    bus_read(2'd1, rd); check("R1 mask after reset", rd, 32'd0);
    bus_read(2'd2, rd); check("R1 vector after reset", rd, 32'd64);

    // Vector table: R2 R7 R8 R9 R6
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0]  te = TBL[v][39:32];
      logic [7:0]  tn = TBL[v][31:24];
      logic [15:0] tm = TBL[v][23:8];
      logic [7:0]  tv = TBL[v][7:0];
      bus_write(2'd1, {16'h0, tm});
      drive_settle(te, tn);
      check("R6 irq level", {31'b0, irq_o}, {31'b0, (tv != 8'd64)});
      bus_read(2'd2, rd); check("R7/R8/R9 vector", rd, {24'b0, tv});
      bus_read(2'd0, rd); check("R2 pending", rd, weave(te, tn));
    end

    // R3 and R6 timing: pending follows level, irq two clocks after input
    bus_write(2'd1, 32'h0000_0040);        // position 6 = ext pin 3
    drive_settle(8'h00, 8'h00);
    @(negedge clk);
    ext_req = 8'h08;
    @(posedge clk);
    @(negedge clk);
    check("R6 irq not yet after one clock", {31'b0, irq_o}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R6 irq after two clocks", {31'b0, irq_o}, 32'd1);
    bus_read(2'd0, rd); check("R3 pending set", rd, 32'h0000_0040);
    drive_settle(8'h00, 8'h00);
    bus_read(2'd0, rd); check("R3 pending cleared", rd, 32'd0);
    check("R3 irq dropped", {31'b0, irq_o}, 32'd0);

    // R4 write to pending ignored
    drive_settle(8'h00, 8'h04);            // position 5
    bus_write(2'd0, 32'hFFFF_FFFF);
    bus_read(2'd0, rd); check("R4 pending unchanged", rd, 32'h0000_0020);
    bus_read(2'd1, rd); check("R4 mask unchanged", rd, 32'h0000_0040);

    // R5 mask width
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_read(2'd1, rd); check("R5 mask upper bits zero", rd, 32'h0000_FFFF);

    // R10 spare and vector addresses
    bus_write(2'd1, 32'h0000_1234);
    bus_write(2'd2, 32'hFFFF_FFFF);
    bus_write(2'd3, 32'hFFFF_FFFF);
    bus_read(2'd1, rd); check("R10 mask unchanged by writes to 2/3", rd, 32'h0000_1234);
    bus_read(2'd3, rd); check("R10 spare reads zero", rd, 32'd0);
    bus_read(2'd2, rd); check("R10 vector after ignored write", rd, 32'd20);

    // R11 read latency: rdata reflects address of previous edge
    @(negedge clk);
    bus_addr = 2'd1;
    @(posedge clk);
    @(negedge clk);
    bus_addr = 2'd3;
    check("R11 registered read", bus_rdata, 32'h0000_1234);
    @(posedge clk);
    @(negedge clk);
    check("R11 next read", bus_rdata, 32'd0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule